// File: doc/BRIEF.md
# Display and Keypad Controller I2C Slave Port

This block is the serial front end of a segment-display and keypad controller. It listens on a two-wire I2C bus and recognises one fixed 7-bit device address. After a write address, the first data byte is either a command opcode or a register pointer. A command opcode updates one of three configuration registers: power state and display enable, drive layout and interrupt pin setup, or key-scan period. A pointer selects a location for the data bytes that follow.

In a read transaction, the block returns a display RAM byte, a key data byte or the interrupt flag, depending on the pointer. The pointer advances after every byte the master acknowledges. Each register region has its own wrap rule. The display RAM and key registers are outside this block. The block reaches them through a simple address/data port. A key-read-done pulse tells the key logic that a complete key read has taken place, so that it can clear its state.

SCL and SDA are brought into the system clock domain through a synchroniser and a stability filter. The block drives the bus only by pulling SDA low, and it changes that output only while SCL is low.

Top module: `dispkey_i2c_port`

## Requirements
- R1: After reset, the display is off and the block is in standby (S=0). The layout is the 4-common one, the shared pin is a segment, the interrupt polarity is active-low and the scan period code is 0. SDA is released.
- R2: The block acknowledges an address byte only when its upper seven bits equal 1110011. Bit 0 set to 1 selects a read. A byte with any other address gets no acknowledge, and the block ignores the rest of that transaction.
- R3: The system command, binary 100000DS, sets display-on from bit 1 and normal operation from bit 0. Bit 0 set to 0 selects standby. The command is accepted in every state.
- R4: In normal operation, command 10100ACM sets three fields: A (bit 2) makes the interrupt active-high, C (bit 1) gives the shared pin to the interrupt, and M (bit 0) selects the 8-common layout. In normal operation, command 11111PPP sets the key-scan period code. In standby, these commands and all display RAM writes are ignored.
- R5: A first data byte with bit 7 set that matches no command changes nothing. In a write whose first byte was a command, all later bytes are ignored.
- R6: A first data byte with bit 7 clear is loaded as the pointer. Each later data byte is written to display RAM at the pointer, and the pointer then advances. It wraps to 0x00 after 0x09 in the 4-common layout and after 0x0F in the 8-common layout. A byte whose pointer lies outside the current display range is not written.
- R7: Read bytes are sent MSB first. Each byte acknowledged by the master advances the pointer. In display RAM the pointer wraps from 0x0F to 0x00, and in the key registers from 0x22 to 0x20. A master NACK leaves SDA released. SDA changes only while SCL is low.
- R8: Reading pointer 0x30 returns the interrupt flag in bit 0, with all other bits zero.
- R9: key_read_done_o is a single-cycle pulse. It is issued when a read that started at pointer 0x20 has advanced onto 0x22 and the transaction then ends with a STOP or repeated START. A read that starts anywhere else never issues it.
- R10: START is SDA falling while SCL is high. STOP is SDA rising while SCL is high. A repeated START begins a new address phase and keeps the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| ram_we_o | output | 1 | Display RAM write strobe |
| ram_addr_o | output | 4 | Display RAM address, used for both write and read |
| ram_wdata_o | output | 8 | Display RAM write data |
| ram_rdata_i | input | 8 | Display RAM read data at ram_addr_o |
| key_addr_o | output | 2 | Key register index (pointer minus 0x20) |
| key_rdata_i | input | 8 | Key register data at key_addr_o |
| int_flag_i | input | 1 | Current interrupt flag |
| key_read_done_o | output | 1 | Pulse after a complete key read |
| cfg_display_on_o | output | 1 | Display enable |
| cfg_normal_o | output | 1 | 1 normal, 0 standby |
| cfg_mode8_o | output | 1 | 1 selects the 8-common layout |
| cfg_int_pin_o | output | 1 | 1 gives the shared pin to the interrupt |
| cfg_int_high_o | output | 1 | 1 makes the interrupt active-high |
| cfg_scan_period_o | output | 3 | Key-scan period code |

## Verification
On every cycle the assertions check four things. SDA moves only while the filtered SCL is low. RAM writes happen only in normal operation and only inside the current display range. The layout and scan fields hold still while in standby. The key-read-done output is never longer than one cycle.

Only the bench scenarios can show the rest. These include the address decode and its NACK, the decode of each command byte, and the ignore rule after a command. They also cover the write and read pointer wraps in both layouts, MSB-first serialisation, the interrupt-flag byte, and whether a key read counts as complete.

// File: rtl/dk_pkg.sv
package dk_pkg;
  localparam int BYTE_W = 8;
  localparam int PTR_W  = 8;
  localparam int RAM_AW = 4;
  localparam int KEY_AW = 2;

  typedef enum logic [2:0] {
    LK_IDLE, LK_RX, LK_RXEND, LK_RACK, LK_TX, LK_MACK, LK_MNEXT
  } link_st_t;

  localparam logic [PTR_W-1:0]  PTR_KEY_LO = 8'h20;
  localparam logic [PTR_W-1:0]  PTR_KEY_MID = 8'h21;
  localparam logic [PTR_W-1:0]  PTR_KEY_HI = 8'h22;
  localparam logic [PTR_W-1:0]  PTR_FLAG   = 8'h30;
  localparam logic [RAM_AW-1:0] LAST_DISP_4 = 4'h9;
  localparam logic [RAM_AW-1:0] LAST_DISP_8 = 4'hF;

  localparam logic [5:0] OPC_SYS    = 6'b100000;
  localparam logic [4:0] OPC_MODE   = 5'b10100;
  localparam logic [4:0] OPC_PERIOD = 5'b11111;

  typedef struct packed {
    logic       disp_on;
    logic       normal;
    logic       mode8;
    logic       int_pin;
    logic       int_high;
    logic [2:0] scan_per;
  } cfg_t;
endpackage

// File: rtl/dk_pin_filter.sv
module dk_pin_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYC    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic pin_o
);
  localparam int CNT_W = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);

  logic             raw;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flt_q, flt_d;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      logic s_q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) s_q <= 1'b1;
        else        s_q <= pin_i;
      assign raw = s_q;
    end else begin : g_chain
      logic [SYNC_STAGES-1:0] s_q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) s_q <= '1;
        else        s_q <= {s_q[SYNC_STAGES-2:0], pin_i};
      assign raw = s_q[SYNC_STAGES-1];
    end
  endgenerate

  // Output follows the synchronised pin only after HOLD_CYC equal samples
  always_comb begin
    cnt_d = '0;
    flt_d = flt_q;
    if (raw != flt_q) begin
      if (cnt_q == HOLD_LAST) begin
        flt_d = raw;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q <= '0;
      flt_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      flt_q <= flt_d;
    end

  assign pin_o = flt_q;
endmodule

// File: rtl/dk_link.sv
module dk_link
  import dk_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h73
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_f,
  input  logic              sda_f,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              sda_pull,
  output logic              ev_start,
  output logic              ev_stop,
  output logic              ev_wbyte,
  output logic [BYTE_W-1:0] wbyte,
  output logic              ev_rd_begin,
  output logic              ev_rd_adv
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  link_st_t          st_q, st_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              first_q, first_d;
  logic              rd_q, rd_d;
  logic              ackp_q, ackp_d;
  logic              pull_q, pull_d;
  logic              scl_q, sda_q;
  logic              rise, fall, start_det, stop_det;
  logic [BYTE_W-1:0] rx_byte;
  logic              addr_hit;

  assign rise      = scl_f & ~scl_q;
  assign fall      = ~scl_f & scl_q;
  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
  assign rx_byte   = {sh_q[BYTE_W-2:0], sda_f};
  assign addr_hit  = (rx_byte[BYTE_W-1:1] == SLAVE_ADDR);
  assign wbyte     = rx_byte;

  always_comb begin
    st_d        = st_q;
    sh_d        = sh_q;
    cnt_d       = cnt_q;
    first_d     = first_q;
    rd_d        = rd_q;
    ackp_d      = ackp_q;
    pull_d      = pull_q;
    ev_start    = 1'b0;
    ev_stop     = 1'b0;
    ev_wbyte    = 1'b0;
    ev_rd_begin = 1'b0;
    ev_rd_adv   = 1'b0;
    if (start_det) begin
      st_d     = LK_RX;
      cnt_d    = '0;
      first_d  = 1'b1;
      rd_d     = 1'b0;
      pull_d   = 1'b0;
      ev_start = 1'b1;
    end else if (stop_det) begin
      st_d    = LK_IDLE;
      pull_d  = 1'b0;
      ev_stop = 1'b1;
    end else begin
      unique case (st_q)
        LK_RX: if (rise) begin
          sh_d  = rx_byte;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST_BIT) begin
            st_d    = LK_RXEND;
            first_d = 1'b0;
            if (first_q) begin
              ackp_d      = addr_hit;
              rd_d        = rx_byte[0];
              ev_rd_begin = addr_hit & rx_byte[0];
            end else begin
              ackp_d   = 1'b1;
              ev_wbyte = 1'b1;
            end
          end
        end
        LK_RXEND: if (fall) begin
          if (ackp_q) begin
            pull_d = 1'b1;
            st_d   = LK_RACK;
          end else begin
            st_d = LK_IDLE;
          end
        end
        LK_RACK: if (fall) begin
          cnt_d = '0;
          if (rd_q) begin
            st_d   = LK_TX;
            sh_d   = tx_byte;
            pull_d = ~tx_byte[BYTE_W-1];
          end else begin
            st_d   = LK_RX;
            pull_d = 1'b0;
          end
        end
        LK_TX: if (fall) begin
          if (cnt_q == LAST_BIT) begin
            pull_d = 1'b0;
            st_d   = LK_MACK;
          end else begin
            sh_d   = {sh_q[BYTE_W-2:0], 1'b0};
            pull_d = ~sh_q[BYTE_W-2];
            cnt_d  = cnt_q + 1'b1;
          end
        end
        LK_MACK: if (rise) begin
          if (!sda_f) begin
            ev_rd_adv = 1'b1;
            st_d      = LK_MNEXT;
          end else begin
            st_d = LK_IDLE;
          end
        end
        LK_MNEXT: if (fall) begin
          st_d   = LK_TX;
          sh_d   = tx_byte;
          pull_d = ~tx_byte[BYTE_W-1];
          cnt_d  = '0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_q    <= LK_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
      first_q <= 1'b0;
      rd_q    <= 1'b0;
      ackp_q  <= 1'b0;
      pull_q  <= 1'b0;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
    end else begin
      st_q    <= st_d;
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      first_q <= first_d;
      rd_q    <= rd_d;
      ackp_q  <= ackp_d;
      pull_q  <= pull_d;
      scl_q   <= scl_f;
      sda_q   <= sda_f;
    end

  assign sda_pull = pull_q;
endmodule

// File: rtl/dk_regs.sv
module dk_regs
  import dk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              ev_wbyte,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic              ev_rd_begin,
  input  logic              ev_rd_adv,
  input  logic [BYTE_W-1:0] ram_rdata,
  input  logic [BYTE_W-1:0] key_rdata,
  input  logic              int_flag,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [BYTE_W-1:0] ram_wdata,
  output logic [KEY_AW-1:0] key_addr,
  output cfg_t              cfg,
  output logic              key_done
);
  cfg_t              cfg_q, cfg_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic              first_q, first_d;
  logic              lock_q, lock_d;
  logic              arm_q, arm_d;
  logic              cov_q, cov_d;
  logic              done_q, done_d;
  logic              we_q, we_d;
  logic [RAM_AW-1:0] wa_q, wa_d;
  logic [BYTE_W-1:0] wd_q, wd_d;
  logic [RAM_AW-1:0] last_disp;
  logic              in_disp, in_key;

  assign last_disp = cfg_q.mode8 ? LAST_DISP_8 : LAST_DISP_4;
  assign in_disp   = (ptr_q[PTR_W-1:RAM_AW] == '0);
  assign in_key    = (ptr_q >= PTR_KEY_LO) && (ptr_q <= PTR_KEY_HI);

  always_comb begin
    if (in_disp)              tx_byte = ram_rdata;
    else if (in_key)          tx_byte = key_rdata;
    else if (ptr_q == PTR_FLAG) tx_byte = {{(BYTE_W-1){1'b0}}, int_flag};
    else                      tx_byte = '0;
  end

  always_comb begin
    cfg_d   = cfg_q;
    ptr_d   = ptr_q;
    first_d = first_q;
    lock_d  = lock_q;
    arm_d   = arm_q;
    cov_d   = cov_q;
    done_d  = 1'b0;
    we_d    = 1'b0;
    wa_d    = wa_q;
    wd_d    = wd_q;
    if (ev_start || ev_stop) begin
      done_d  = arm_q & cov_q;
      arm_d   = 1'b0;
      cov_d   = 1'b0;
      first_d = ev_start;
      lock_d  = 1'b0;
    end
    if (ev_wbyte) begin
      if (first_q) begin
        first_d = 1'b0;
        if (wbyte[BYTE_W-1]) begin
          lock_d = 1'b1;
          if (wbyte[7:2] == OPC_SYS) begin
            cfg_d.disp_on = wbyte[1];
            cfg_d.normal  = wbyte[0];
          end else if ((wbyte[7:3] == OPC_MODE) && cfg_q.normal) begin
            cfg_d.int_high = wbyte[2];
            cfg_d.int_pin  = wbyte[1];
            cfg_d.mode8    = wbyte[0];
          end else if ((wbyte[7:3] == OPC_PERIOD) && cfg_q.normal) begin
            cfg_d.scan_per = wbyte[2:0];
          end
        end else begin
          ptr_d = wbyte;
        end
      end else if (!lock_q && in_disp && (ptr_q[RAM_AW-1:0] <= last_disp)) begin
        we_d = cfg_q.normal;
        wa_d = ptr_q[RAM_AW-1:0];
        wd_d = wbyte;
        ptr_d = (ptr_q[RAM_AW-1:0] == last_disp) ? '0 : ptr_q + 1'b1;
      end
    end
    if (ev_rd_begin) begin
      arm_d = (ptr_q == PTR_KEY_LO);
      cov_d = 1'b0;
    end
    if (ev_rd_adv) begin
      if (arm_q && (ptr_q == PTR_KEY_MID)) cov_d = 1'b1;
      if (in_disp) begin
        ptr_d = (ptr_q[RAM_AW-1:0] == LAST_DISP_8) ? '0 : ptr_q + 1'b1;
      end else if (in_key) begin
        ptr_d = (ptr_q == PTR_KEY_HI) ? PTR_KEY_LO : ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg_q   <= '0;
      ptr_q   <= '0;
      first_q <= 1'b0;
      lock_q  <= 1'b0;
      arm_q   <= 1'b0;
      cov_q   <= 1'b0;
      done_q  <= 1'b0;
      we_q    <= 1'b0;
      wa_q    <= '0;
      wd_q    <= '0;
    end else begin
      cfg_q   <= cfg_d;
      ptr_q   <= ptr_d;
      first_q <= first_d;
      lock_q  <= lock_d;
      arm_q   <= arm_d;
      cov_q   <= cov_d;
      done_q  <= done_d;
      we_q    <= we_d;
      wa_q    <= wa_d;
      wd_q    <= wd_d;
    end

  assign cfg       = cfg_q;
  assign ram_we    = we_q;
  assign ram_addr  = we_q ? wa_q : ptr_q[RAM_AW-1:0];
  assign ram_wdata = wd_q;
  assign key_addr  = ptr_q[KEY_AW-1:0];
  assign key_done  = done_q;
endmodule

// File: rtl/dispkey_i2c_port.sv
module dispkey_i2c_port
  import dk_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h73,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_HOLD   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  output logic       ram_we_o,
  output logic [3:0] ram_addr_o,
  output logic [7:0] ram_wdata_o,
  input  logic [7:0] ram_rdata_i,
  output logic [1:0] key_addr_o,
  input  logic [7:0] key_rdata_i,
  input  logic       int_flag_i,
  output logic       key_read_done_o,
  output logic       cfg_display_on_o,
  output logic       cfg_normal_o,
  output logic       cfg_mode8_o,
  output logic       cfg_int_pin_o,
  output logic       cfg_int_high_o,
  output logic [2:0] cfg_scan_period_o
);
  localparam int N_PINS = 2;

  logic [N_PINS-1:0] pins_raw, pins_flt;
  logic              scl_flt, sda_flt;
  logic              ev_start, ev_stop, ev_wbyte, ev_rd_begin, ev_rd_adv;
  logic [BYTE_W-1:0] wbyte, tx_byte;
  cfg_t              cfg;

  assign pins_raw = {sda_i, scl_i};

  generate
    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
      dk_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .HOLD_CYC(FILT_HOLD)) u_flt (
        .clk(clk), .rst_n(rst_n), .pin_i(pins_raw[g]), .pin_o(pins_flt[g]));
    end
  endgenerate

  assign scl_flt = pins_flt[0];
  assign sda_flt = pins_flt[1];

  dk_link #(.SLAVE_ADDR(SLAVE_ADDR)) u_link (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_flt), .sda_f(sda_flt),
    .tx_byte(tx_byte), .sda_pull(sda_pull_o),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_wbyte(ev_wbyte), .wbyte(wbyte),
    .ev_rd_begin(ev_rd_begin), .ev_rd_adv(ev_rd_adv));

  dk_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_wbyte(ev_wbyte), .wbyte(wbyte),
    .ev_rd_begin(ev_rd_begin), .ev_rd_adv(ev_rd_adv),
    .ram_rdata(ram_rdata_i), .key_rdata(key_rdata_i), .int_flag(int_flag_i),
    .tx_byte(tx_byte), .ram_we(ram_we_o), .ram_addr(ram_addr_o),
    .ram_wdata(ram_wdata_o), .key_addr(key_addr_o), .cfg(cfg),
    .key_done(key_read_done_o));

  assign cfg_display_on_o  = cfg.disp_on;
  assign cfg_normal_o      = cfg.normal;
  assign cfg_mode8_o       = cfg.mode8;
  assign cfg_int_pin_o     = cfg.int_pin;
  assign cfg_int_high_o    = cfg.int_high;
  assign cfg_scan_period_o = cfg.scan_per;
endmodule

// File: rtl/dk_port_checker.sv
module dk_port_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_flt,
  input logic       sda_pull_o,
  input logic       ram_we_o,
  input logic [3:0] ram_addr_o,
  input logic       key_read_done_o,
  input logic       cfg_normal_o,
  input logic       cfg_mode8_o,
  input logic       cfg_int_pin_o,
  input logic       cfg_int_high_o,
  input logic [2:0] cfg_scan_period_o
);
  assert_sda_moves_scl_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_o != $past(sda_pull_o)) |-> !$past(scl_flt));

  assert_write_needs_normal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_o |-> cfg_normal_o);

  assert_write_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_o |-> (cfg_mode8_o || (ram_addr_o <= 4'h9)));

  assert_standby_freezes_cfg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_normal_o |=> ($stable(cfg_mode8_o) && $stable(cfg_int_pin_o) &&
                       $stable(cfg_int_high_o) && $stable(cfg_scan_period_o)));

  assert_done_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    key_read_done_o |=> !key_read_done_o);
endmodule

bind dispkey_i2c_port dk_port_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_flt(scl_flt), .sda_pull_o(sda_pull_o),
  .ram_we_o(ram_we_o), .ram_addr_o(ram_addr_o), .key_read_done_o(key_read_done_o),
  .cfg_normal_o(cfg_normal_o), .cfg_mode8_o(cfg_mode8_o),
  .cfg_int_pin_o(cfg_int_pin_o), .cfg_int_high_o(cfg_int_high_o),
  .cfg_scan_period_o(cfg_scan_period_o));

// File: tb/sim_dispkey_i2c_port.sv
`timescale 1ns/1ps
module sim_dispkey_i2c_port;
  localparam int Q = 12;
  localparam logic [7:0] AW = 8'hE6;
  localparam logic [7:0] AR = 8'hE7;
  localparam int NV = 14;
  // {command byte, expected {disp,normal,mode8,intpin,inthigh,period}}
  localparam logic [15:0] VEC [NV] = '{
    16'h81_40, 16'hA7_78, 16'hFD_7D, 16'h90_7D, 16'h83_FD, 16'hC0_FD, 16'h84_FD,
    16'hA2_D5, 16'h82_95, 16'hF9_95, 16'hA1_95, 16'h81_55, 16'hF8_50, 16'hA0_40};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull_o, ram_we_o, key_read_done_o, int_flag_i;
  logic [3:0] ram_addr_o;
  logic [7:0] ram_wdata_o, ram_rdata_i, key_rdata_i;
  logic [1:0] key_addr_o;
  logic cfg_display_on_o, cfg_normal_o, cfg_mode8_o, cfg_int_pin_o, cfg_int_high_o;
  logic [2:0] cfg_scan_period_o;
  logic sda_line;
  logic [7:0] mem [16];
  logic [7:0] keys [4];
  int wr_cnt = 0, done_cnt = 0;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  assign sda_line    = sda_m & ~sda_pull_o;
  assign ram_rdata_i = mem[ram_addr_o];
  assign key_rdata_i = keys[key_addr_o];

  dispkey_i2c_port u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull_o), .ram_we_o(ram_we_o), .ram_addr_o(ram_addr_o),
    .ram_wdata_o(ram_wdata_o), .ram_rdata_i(ram_rdata_i), .key_addr_o(key_addr_o),
    .key_rdata_i(key_rdata_i), .int_flag_i(int_flag_i), .key_read_done_o(key_read_done_o),
    .cfg_display_on_o(cfg_display_on_o), .cfg_normal_o(cfg_normal_o),
    .cfg_mode8_o(cfg_mode8_o), .cfg_int_pin_o(cfg_int_pin_o),
    .cfg_int_high_o(cfg_int_high_o), .cfg_scan_period_o(cfg_scan_period_o));

  always @(posedge clk) begin
    if (ram_we_o) begin
      mem[ram_addr_o] <= ram_wdata_o;
      wr_cnt <= wr_cnt + 1;
    end
    if (key_read_done_o) done_cnt <= done_cnt + 1;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] snap();
    return {cfg_display_on_o, cfg_normal_o, cfg_mode8_o, cfg_int_pin_o,
            cfg_int_high_o, cfg_scan_period_o};
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack_n);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    ack_n = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic get_byte(input logic nack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
      b[i] = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
    end
    put_bit(nack);
  endtask

  task automatic write_seq(input logic [7:0] b0, input logic [7:0] b1,
                           input logic [7:0] b2, input logic [7:0] b3, input int n);
    logic a;
    logic [7:0] bs [4];
    bs[0] = b0; bs[1] = b1; bs[2] = b2; bs[3] = b3;
    bus_start();
    put_byte(AW, a);
    for (int i = 0; i < n; i++) put_byte(bs[i], a);
    bus_stop();
  endtask

  initial begin
    logic a;
    logic [7:0] r;
    int w0, d0;
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    keys[0] = 8'h12; keys[1] = 8'h34; keys[2] = 8'h0F; keys[3] = 8'hFF;
    int_flag_i = 1'b1;
    tick(5);
    check("R1 cfg in reset", {24'h0, snap()}, 32'h00);
    rst_n = 1'b1;
    tick(5);
    check("R1 cfg after reset", {24'h0, snap()}, 32'h00);
    check("R1 sda released", {31'h0, sda_pull_o}, 32'h0);

    // R3/R4/R5 command table
    for (int v = 0; v < NV; v++) begin
      bus_start();
      put_byte(AW, a);
      check("R2 address ack", {31'h0, a}, 32'h0);
      put_byte(VEC[v][15:8], a);
      bus_stop();
      tick(4);
      check($sformatf("R3/R4/R5 vec %0d", v), {24'h0, snap()}, {24'h0, VEC[v][7:0]});
    end

    // R2 foreign address
    bus_start();
    put_byte(8'hE4, a);
    check("R2 foreign address nack", {31'h0, a}, 32'h1);
    put_byte(8'h83, a);
    check("R2 later byte nack", {31'h0, a}, 32'h1);
    bus_stop(); tick(4);
    check("R2 cfg untouched", {24'h0, snap()}, 32'h40);

    // R5 bytes after a command are ignored
    w0 = wr_cnt;
    write_seq(8'h81, 8'h05, 8'h55, 8'h00, 3);
    check("R5 no write after command", wr_cnt - w0, 0);

    // R6 4-common wrap 0x09 -> 0x00
    write_seq(8'h08, 8'hA1, 8'hA2, 8'hA3, 4);
    check("R6 mem8", {24'h0, mem[8]}, 32'hA1);
    check("R6 mem9", {24'h0, mem[9]}, 32'hA2);
    check("R6 wrap to mem0", {24'h0, mem[0]}, 32'hA3);
    w0 = wr_cnt;
    write_seq(8'h0A, 8'hEE, 8'h00, 8'h00, 2);
    check("R6 out of range ignored", wr_cnt - w0, 0);

    // R6 8-common wrap 0x0F -> 0x00
    write_seq(8'hA1, 8'h00, 8'h00, 8'h00, 1);
    write_seq(8'h0E, 8'hB1, 8'hB2, 8'hB3, 4);
    check("R6 mem14", {24'h0, mem[14]}, 32'hB1);
    check("R6 mem15", {24'h0, mem[15]}, 32'hB2);
    check("R6 wrap8 mem0", {24'h0, mem[0]}, 32'hB3);

    // R7/R10 display read after repeated start, wrap 0x0F -> 0x00
    bus_start(); put_byte(AW, a); put_byte(8'h0F, a);
    bus_start(); put_byte(AR, a);
    check("R10 read address ack", {31'h0, a}, 32'h0);
    get_byte(1'b0, r); check("R7 read mem15", {24'h0, r}, 32'hB2);
    get_byte(1'b0, r); check("R7 read wrap mem0", {24'h0, r}, 32'hB3);
    get_byte(1'b1, r); check("R7 read mem1", {24'h0, r}, 32'h00);
    check("R7 released after nack", {31'h0, sda_pull_o}, 32'h0);
    bus_stop(); tick(4);

    // R9/R7 full key read from 0x20 with wrap
    d0 = done_cnt;
    bus_start(); put_byte(AW, a); put_byte(8'h20, a);
    bus_start(); put_byte(AR, a);
    check("R9 no pulse on restart before read", done_cnt - d0, 0);
    get_byte(1'b0, r); check("R7 key0", {24'h0, r}, 32'h12);
    get_byte(1'b0, r); check("R7 key1", {24'h0, r}, 32'h34);
    get_byte(1'b0, r); check("R7 key2", {24'h0, r}, 32'h0F);
    get_byte(1'b1, r); check("R7 key wrap", {24'h0, r}, 32'h12);
    bus_stop(); tick(4);
    check("R9 done pulse", done_cnt - d0, 1);

    // R9 read from 0x21 gives no pulse
    d0 = done_cnt;
    bus_start(); put_byte(AW, a); put_byte(8'h21, a);
    bus_start(); put_byte(AR, a);
    get_byte(1'b0, r); get_byte(1'b1, r);
    check("R7 key2 from 0x21 path", {24'h0, r}, 32'h0F);
    bus_stop(); tick(4);
    check("R9 no pulse from 0x21", done_cnt - d0, 0);

    // R8 interrupt flag
    bus_start(); put_byte(AW, a); put_byte(8'h30, a);
    bus_start(); put_byte(AR, a);
    get_byte(1'b1, r);
    bus_stop(); tick(4);
    check("R8 flag byte", {24'h0, r}, 32'h01);

    // R4 standby blocks RAM writes
    write_seq(8'h80, 8'h00, 8'h00, 8'h00, 1);
    w0 = wr_cnt;
    write_seq(8'h03, 8'h77, 8'h00, 8'h00, 2);
    check("R4 standby write ignored", wr_cnt - w0, 0);
    check("R4 standby mem3", {24'h0, mem[3]}, 32'h00);
    write_seq(8'h81, 8'h00, 8'h00, 8'h00, 1);
    check("R3 back to normal", {31'h0, cfg_normal_o}, 32'h1);

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule